// File: doc/BRIEF.md
# Configurable Burst Read Address Sequencer

This block produces the word-address stream for a synchronous burst read from a memory array. It issues one address with a data-valid flag per active clock edge, and it pulses a burst-done flag when a fixed-length burst completes. The array itself and any wait-state logic sit outside the block.

Before a burst, the host writes a configuration word. The word selects one of three address modes: linear fixed length, wrap inside an aligned window, or unbounded continuous. It also selects the burst length and the active clock edge. A start strobe, qualified by chip-enable and burst-request, launches a burst from the given start address. The address leaves the block as a valid/ready stream. While `valid_o` is high and `out_ready_i` is low, the sequencer holds the current address and word count and does not advance. When the sink has accepted the current word (`valid_o` and `out_ready_i` both high at an active edge), the next address follows. `valid_o` never depends on `out_ready_i`, and a sink may hold ready low for any number of edges.

The active edge is rising or falling, chosen by a configuration bit. That edge samples the start strobe and the stream inputs, and it is the only edge on which the outputs change. Configuration writes are always taken on the rising edge. A write made while a burst runs is parked and applied once the sequencer is idle.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous reset (`rst_i` high at a rising edge) clears `valid_o` and `done_o`. It also abandons any burst and restores the defaults: linear mode, length 8, rising active edge.
- R2: The length code `cfg_len_i` selects 8 (0), 16 (1) or 32 (2 or 3) words. The code in force when a burst launches governs that burst and every later burst until it is rewritten.
- R3: In wrap mode (`cfg_mode_i` = 1) with length L, every address stays in the L-word block aligned by clearing the low log2(L) bits of the start address. After the last word of that block, the address rolls to the block start. Exactly L words are issued.
- R4: In linear mode (`cfg_mode_i` = 0, or the spare code 3), the address rises by one for each accepted word, for exactly L words. `valid_o` then drops, and `done_o` is high for one active edge.
- R5: In continuous mode (`cfg_mode_i` = 2), the address keeps incrementing with no length limit and rolls over at the address width. `done_o` is never raised.
- R6: With `cfg_fall_i` = 1 the active edge is falling, and the outputs do not change on rising edges.
- R7: At the active edge where `start_i`, `ce_i` and `req_i` are all high and the sequencer is idle, `valid_o` rises and `addr_o` equals `start_addr_i`.
- R8: An active edge with `ce_i` or `req_i` low during a burst ends the burst. `valid_o` is low from that edge on, and `done_o` stays low.
- R9: A configuration write (`cfg_we_i` at a rising edge) during a burst does not alter that burst. It takes effect on the first rising edge at which the sequencer is idle and `start_i` is low.
- R10: While `valid_o` is high and `out_ready_i` is low, `addr_o` and the word count hold.
- R11: `start_i` is ignored while a burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; both edges used, one selected as active |
| rst_i | input | 1 | Synchronous reset, active high, sampled on rising edge |
| cfg_we_i | input | 1 | Configuration write strobe (rising edge) |
| cfg_mode_i | input | 2 | 0 linear, 1 wrap, 2 continuous, 3 linear |
| cfg_len_i | input | 2 | 0: 8 words, 1: 16, 2 or 3: 32 |
| cfg_fall_i | input | 1 | 1 selects the falling edge as active |
| ce_i | input | 1 | Chip enable; low ends a burst |
| req_i | input | 1 | Burst request; low ends a burst |
| start_i | input | 1 | Burst launch strobe |
| start_addr_i | input | ADDR_W | Initial word address |
| out_ready_i | input | 1 | Sink ready for the address stream |
| addr_o | output | ADDR_W | Current array word address |
| valid_o | output | 1 | Address/data valid |
| done_o | output | 1 | One-edge pulse after a fixed-length burst completes |

## Verification
The bench builds the block with a 12-bit address and the default three lengths of 8, 16 and 32 words. The narrow address lets a continuous burst cross the top of the address space within a few dozen edges, so the rollover of R5 can be seen. The length set puts every length code, including the spare code 3, and both unaligned wrap windows and a 32-word window starting near its top within a short run. Falling-edge mode is exercised with inputs driven between edges, so that a response on the wrong edge shows up at the ports.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  typedef enum logic [1:0] {
    MODE_LIN  = 2'd0,
    MODE_WRAP = 2'd1,
    MODE_CONT = 2'd2,
    MODE_SPARE = 2'd3
  } mode_e;

  typedef struct packed {
    mode_e      mode;
    logic [1:0] len_code;
    logic       fall;
  } cfg_t;

  localparam cfg_t CFG_DEFAULT = '{mode: MODE_LIN, len_code: 2'd0, fall: 1'b0};

endpackage

// File: rtl/bseq_cfg.sv
module bseq_cfg
  import bseq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic we_i,
  input  cfg_t wdata_i,
  input  logic idle_i,
  input  logic start_i,
  output cfg_t act_o
);

  cfg_t act_q;
  cfg_t park_q;
  logic park_v_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      act_q    <= CFG_DEFAULT;
      park_q   <= CFG_DEFAULT;
      park_v_q <= 1'b0;
    end else if (we_i) begin
      park_q   <= wdata_i;
      park_v_q <= 1'b1;
    end else if (park_v_q && idle_i && !start_i) begin
      act_q    <= park_q;
      park_v_q <= 1'b0;
    end
  end

  assign act_o = act_q;

  // Active configuration (including edge polarity) only moves while idle
  assert_cfg_idle_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && !$stable(act_q)) |-> ($past(idle_i) && !$past(start_i)));

  assert_pol_idle_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && !$stable(act_q.fall)) |-> $past(idle_i));

endmodule

// File: rtl/bseq_len.sv
module bseq_len #(
  parameter int ADDR_W       = 24,
  parameter int LEN_LOG2_MIN = 3,
  parameter int NUM_LEN      = 3,
  localparam int CNT_W       = LEN_LOG2_MIN + NUM_LEN
) (
  input  logic [1:0]        code_i,
  output logic [CNT_W-1:0]  len_o,
  output logic [ADDR_W-1:0] mask_o
);

  logic [CNT_W-1:0]  len_tab  [4];
  logic [ADDR_W-1:0] mask_tab [4];

  for (genvar g = 0; g < 4; g++) begin : g_code
    localparam int EXP = LEN_LOG2_MIN + ((g < NUM_LEN) ? g : NUM_LEN - 1);
    assign len_tab[g]  = CNT_W'(1) << EXP;
    assign mask_tab[g] = (ADDR_W'(1) << EXP) - ADDR_W'(1);
  end

  assign len_o  = len_tab[code_i];
  assign mask_o = mask_tab[code_i];

endmodule

// File: rtl/bseq_step.sv
module bseq_step
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] mask_i,
  input  mode_e             mode_i,
  output logic [ADDR_W-1:0] next_o
);

  logic [ADDR_W-1:0] inc;
  logic [ADDR_W-1:0] rolled;

  assign inc    = addr_i + ADDR_W'(1);
  assign rolled = (addr_i & ~mask_i) | (inc & mask_i);
  assign next_o = (mode_i == MODE_WRAP) ? rolled : inc;

endmodule

// File: rtl/bseq_core.sv
module bseq_core
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              pol_i,
  input  mode_e             mode_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic [ADDR_W-1:0] mask_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              ce_i,
  input  logic              req_i,
  input  logic              ready_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              valid_o,
  output logic              done_o,
  output logic              busy_o
);

  typedef struct packed {
    logic              busy;
    logic              done;
    logic [CNT_W-1:0]  idx;
    logic [ADDR_W-1:0] addr;
  } st_t;

  st_t st_rise_q;
  st_t st_fall_q;
  st_t cur;
  st_t nxt;
  logic [ADDR_W-1:0] step_addr;

  assign cur = pol_i ? st_fall_q : st_rise_q;

  bseq_step #(.ADDR_W(ADDR_W)) u_step (
    .addr_i (cur.addr),
    .mask_i (mask_i),
    .mode_i (mode_i),
    .next_o (step_addr)
  );

  always_comb begin
    nxt      = cur;
    nxt.done = 1'b0;
    if (!cur.busy) begin
      if (start_i && ce_i && req_i) begin
        nxt.busy = 1'b1;
        nxt.addr = start_addr_i;
        nxt.idx  = CNT_W'(1);
      end
    end else if (!ce_i || !req_i) begin
      nxt.busy = 1'b0;
    end else if (ready_i) begin
      if (mode_i == MODE_CONT) begin
        nxt.addr = step_addr;
      end else if (cur.idx == len_i) begin
        nxt.busy = 1'b0;
        nxt.done = 1'b1;
      end else begin
        nxt.addr = step_addr;
        nxt.idx  = cur.idx + CNT_W'(1);
      end
    end
  end

  // Each edge copy advances only when its edge is the active one; the
  // inactive copy tracks the other so a polarity switch sees current state.
  always_ff @(posedge clk_i) begin
    if (rst_i)       st_rise_q <= '0;
    else if (!pol_i) st_rise_q <= nxt;
    else             st_rise_q <= st_fall_q;
  end

  always_ff @(negedge clk_i) begin
    if (rst_i)      st_fall_q <= '0;
    else if (pol_i) st_fall_q <= nxt;
    else            st_fall_q <= st_rise_q;
  end

  assign addr_o  = cur.addr;
  assign valid_o = cur.busy;
  assign done_o  = cur.done;
  assign busy_o  = cur.busy;

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    (!pol_i && valid_o && !ready_i && ce_i && req_i) |=> (valid_o && $stable(addr_o)));

  assert_abort_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (!pol_i && valid_o && (!ce_i || !req_i)) |=> (!valid_o && !done_o));

  assert_done_pulse_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (!pol_i && done_o) |=> !done_o);

  assert_done_idle_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |-> !valid_o);

  assert_count_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (valid_o && mode_i != MODE_CONT) |-> (cur.idx >= CNT_W'(1) && cur.idx <= len_i));

  assert_wrap_window_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && !pol_i && $past(!pol_i) && valid_o && mode_i == MODE_WRAP &&
     $past(valid_o && ready_i && ce_i && req_i))
      |-> (((addr_o ^ $past(addr_o)) & ~mask_i) == '0));

  assert_linear_step_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && !pol_i && $past(!pol_i) && valid_o && mode_i == MODE_LIN &&
     $past(valid_o && ready_i && ce_i && req_i))
      |-> (addr_o == $past(addr_o) + ADDR_W'(1)));

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bseq_pkg::*;
#(
  parameter int ADDR_W       = 24,
  parameter int LEN_LOG2_MIN = 3,
  parameter int NUM_LEN      = 3
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_mode_i,
  input  logic [1:0]        cfg_len_i,
  input  logic              cfg_fall_i,
  input  logic              ce_i,
  input  logic              req_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              out_ready_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              valid_o,
  output logic              done_o
);

  localparam int CNT_W = LEN_LOG2_MIN + NUM_LEN;

  cfg_t              wcfg;
  cfg_t              act;
  mode_e             eff_mode;
  logic [CNT_W-1:0]  len;
  logic [ADDR_W-1:0] mask;
  logic              busy;

  assign wcfg = '{mode: mode_e'(cfg_mode_i), len_code: cfg_len_i, fall: cfg_fall_i};

  // The spare mode code behaves as linear
  assign eff_mode = (act.mode == MODE_SPARE) ? MODE_LIN : act.mode;

  bseq_cfg u_cfg (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .we_i    (cfg_we_i),
    .wdata_i (wcfg),
    .idle_i  (!busy),
    .start_i (start_i),
    .act_o   (act)
  );

  bseq_len #(
    .ADDR_W       (ADDR_W),
    .LEN_LOG2_MIN (LEN_LOG2_MIN),
    .NUM_LEN      (NUM_LEN)
  ) u_len (
    .code_i (act.len_code),
    .len_o  (len),
    .mask_o (mask)
  );

  bseq_core #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) u_core (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .pol_i        (act.fall),
    .mode_i       (eff_mode),
    .len_i        (len),
    .mask_i       (mask),
    .start_i      (start_i),
    .start_addr_i (start_addr_i),
    .ce_i         (ce_i),
    .req_i        (req_i),
    .ready_i      (out_ready_i),
    .addr_o       (addr_o),
    .valid_o      (valid_o),
    .done_o       (done_o),
    .busy_o       (busy)
  );

endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb_top;

  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst, cfg_we, cfg_fall, ce, req, start, ready;
  logic [1:0]    cfg_mode, cfg_len;
  logic [AW-1:0] start_addr, addr;
  logic          valid, done;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  fall_mode = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .LEN_LOG2_MIN(3), .NUM_LEN(3)) dut_i (
    .clk_i (clk), .rst_i (rst), .cfg_we_i (cfg_we), .cfg_mode_i (cfg_mode),
    .cfg_len_i (cfg_len), .cfg_fall_i (cfg_fall), .ce_i (ce), .req_i (req),
    .start_i (start), .start_addr_i (start_addr), .out_ready_i (ready),
    .addr_o (addr), .valid_o (valid), .done_o (done)
  );

  task automatic chk(input bit ok, input string r, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  task automatic tick();
    if (fall_mode) @(negedge clk);
    else           @(posedge clk);
    #1;
  endtask

  function automatic int len_of(input int code);
    return (code == 0) ? 8 : (code == 1) ? 16 : 32;
  endfunction

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] s, input int k,
                                             input int mode, input int len);
    logic [AW-1:0] m;
    m = AW'(len - 1);
    if (mode == 1) return (s & ~m) | ((s + AW'(k)) & m);
    return s + AW'(k);
  endfunction

  task automatic write_cfg(input int mode, input int code, input bit f);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_mode = 2'(mode); cfg_len = 2'(code); cfg_fall = f;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic run_burst(input logic [AW-1:0] s, input int mode, input int len,
                           input string r);
    start = 1'b1; start_addr = s;
    tick();
    start = 1'b0;
    for (int k = 0; k < len; k++) begin
      chk(valid === 1'b1, r, "valid in burst", int'(valid), 1);
      chk(addr === exp_addr(s, k, mode, len), r, "burst address",
          int'(addr), int'(exp_addr(s, k, mode, len)));
      tick();
    end
    chk(valid === 1'b0 && done === 1'b1, r, "done after last word", int'({valid, done}), 1);
    tick();
    chk(done === 1'b0, r, "done lasts one edge", int'(done), 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1; rst = 1'b0;
    chk(valid === 1'b0, "R1", "valid after reset", int'(valid), 0);
    chk(done === 1'b0, "R1", "done after reset", int'(done), 0);
    run_burst(12'h00D, 0, 8, "R1");
  endtask

  task automatic t_lengths();
    write_cfg(0, 1, 1'b0);
    run_burst(12'h100, 0, 16, "R2");
    run_burst(12'h1F8, 0, 16, "R4");
    write_cfg(3, 3, 1'b0);
    run_burst(12'h000, 0, 32, "R2");
  endtask

  task automatic t_wrap();
    write_cfg(1, 0, 1'b0);
    run_burst(12'h00D, 1, 8, "R3");
    write_cfg(1, 2, 1'b0);
    run_burst(12'h03A, 1, 32, "R3");
    write_cfg(1, 1, 1'b0);
    run_burst(12'h270, 1, 16, "R3");
  endtask

  task automatic t_cont();
    write_cfg(2, 0, 1'b0);
    start = 1'b1; start_addr = 12'hFF0;
    tick();
    start = 1'b0;
    for (int k = 0; k < 40; k++) begin
      chk(valid === 1'b1 && done === 1'b0, "R5", "continuous valid", int'({valid, done}), 2);
      chk(addr === 12'(12'hFF0 + k), "R5", "continuous address", int'(addr),
          int'(12'(12'hFF0 + k)));
      tick();
    end
    req = 1'b0;
    tick();
    chk(valid === 1'b0 && done === 1'b0, "R8", "req low ends burst", int'({valid, done}), 0);
    req = 1'b1;
    tick();
  endtask

  task automatic t_abort();
    write_cfg(0, 1, 1'b0);
    start = 1'b1; start_addr = 12'h200;
    tick();
    start = 1'b0;
    repeat (3) tick();
    chk(addr === 12'h203, "R8", "address before abort", int'(addr), 'h203);
    ce = 1'b0;
    tick();
    chk(valid === 1'b0 && done === 1'b0, "R8", "ce low ends burst", int'({valid, done}), 0);
    tick();
    chk(valid === 1'b0, "R8", "stays idle", int'(valid), 0);
    ce = 1'b1;
    tick();
  endtask

  task automatic t_backpressure();
    write_cfg(0, 0, 1'b0);
    start = 1'b1; start_addr = 12'h040;
    tick();
    start = 1'b0;
    ready = 1'b0;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk(valid === 1'b1 && addr === 12'h040, "R10", "hold while not ready", int'(addr), 'h40);
    end
    ready = 1'b1;
    for (int k = 0; k < 8; k++) begin
      chk(addr === 12'(12'h040 + k), "R10", "resume after stall", int'(addr),
          int'(12'(12'h040 + k)));
      tick();
    end
    chk(done === 1'b1, "R10", "exact count after stall", int'(done), 1);
    tick();
  endtask

  task automatic t_start_busy();
    start = 1'b1; start_addr = 12'h010;
    tick();
    start = 1'b0;
    tick();
    start = 1'b1; start_addr = 12'h777;
    tick();
    start = 1'b0;
    chk(addr === 12'h012, "R11", "restart ignored", int'(addr), 'h012);
    for (int k = 2; k < 8; k++) tick();
    chk(done === 1'b1, "R11", "original length kept", int'(done), 1);
    tick();
  endtask

  task automatic t_defer();
    start = 1'b1; start_addr = 12'h080;
    tick();
    start = 1'b0;
    for (int k = 0; k < 8; k++) begin
      chk(addr === 12'(12'h080 + k), "R9", "burst unchanged by write", int'(addr),
          int'(12'(12'h080 + k)));
      cfg_we = (k == 2); cfg_mode = 2'd1; cfg_len = 2'd2; cfg_fall = 1'b0;
      tick();
    end
    cfg_we = 1'b0;
    chk(done === 1'b1, "R9", "old length kept", int'(done), 1);
    tick();
    run_burst(12'h05C, 1, 32, "R9");
  endtask

  task automatic t_falling();
    write_cfg(0, 0, 1'b1);
    fall_mode = 1'b1;
    @(negedge clk); #1;
    start = 1'b1; start_addr = 12'h030;
    @(posedge clk); #1;
    chk(valid === 1'b0, "R6", "no launch on rising edge", int'(valid), 0);
    @(negedge clk); #1;
    start = 1'b0;
    chk(valid === 1'b1 && addr === 12'h030, "R7", "launch on falling edge", int'(addr), 'h030);
    @(posedge clk); #1;
    chk(addr === 12'h030, "R6", "no step on rising edge", int'(addr), 'h030);
    for (int k = 1; k < 8; k++) begin
      tick();
      chk(addr === 12'(12'h030 + k), "R6", "falling-edge step", int'(addr),
          int'(12'(12'h030 + k)));
    end
    tick();
    chk(done === 1'b1, "R6", "done in falling mode", int'(done), 1);
    tick();
    write_cfg(0, 0, 1'b0);
    fall_mode = 1'b0;
    run_burst(12'h0A0, 0, 8, "R7");
  endtask

  task automatic t_reset_mid();
    write_cfg(1, 1, 1'b0);
    start = 1'b1; start_addr = 12'h123;
    tick();
    start = 1'b0;
    tick();
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk(valid === 1'b0, "R1", "reset ends burst", int'(valid), 0);
    run_burst(12'h00D, 0, 8, "R1");
  endtask

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_mode = 2'd0; cfg_len = 2'd0; cfg_fall = 1'b0;
    ce = 1'b1; req = 1'b1; start = 1'b0; start_addr = '0; ready = 1'b1;
    t_reset();
    t_lengths();
    t_wrap();
    t_cont();
    t_abort();
    t_backpressure();
    t_start_busy();
    t_defer();
    t_falling();
    t_reset_mid();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #900us;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule